// File: doc/BRIEF.md
# USB Host Controller Command and Status Register

This block holds the command word that host-controller driver software uses to start actions in the controller core. It also keeps a small counter of missed periodic schedules. Software reaches it through a flat register port with an address, a write enable, write data and combinational read data. Command bits can only be set by software. The core clears each one with a completion pulse. Because of this, several commands can be issued in a row without read-modify-write, and no command is lost to a race.

The block also owns two flags of the interrupt status word: the missed-schedule flag and the handoff flag. These flags sit at their own address and are cleared by writing 1 to them. Every other interrupt source, frame timing and list processing lives elsewhere. Those parts reach this block only as single-cycle event pulses.

Top module: `usbh_cmd_stat_reg`

## Requirements
- R1: After reset, all command bits, the overrun counter and both interrupt flags are 0, and a read at either register address returns 0.
- R2: A write to offset 0x08 sets each command bit whose write-data bit is 1 and leaves each bit written 0 unchanged. The command bits are: core reset at bit 0, control-list filled at bit 1, bulk-list filled at bit 2 and handoff request at bit 3.
- R3: At offset 0x08, the overrun counter reads in bits 17:16. Every other bit reads 0. Writes have no effect on the counter or on any of those other bits.
- R4: The core-reset bit clears on a reset-done pulse. The control-list bit clears on a control-empty pulse. The bulk-list bit clears on a bulk-empty pulse.
- R5: When a write that sets a command bit and the hardware clear for that bit arrive in the same cycle, the bit ends up set.
- R6: Each overrun pulse advances the 2-bit counter by one, wrapping from 3 to 0. This happens whether or not the overrun flag is already set.
- R7: Each overrun pulse sets the overrun flag. The flag is read at offset 0x0C bit 0 and cleared by writing 1 there. If an overrun pulse and that clear arrive in the same cycle, the flag stays set.
- R8: A write with bit 3 set to 1 at offset 0x08 sets both the handoff request and the handoff flag. The handoff flag is read at offset 0x0C bit 1. The request clears only on a handoff-done pulse. The flag clears only by writing 1 to bit 1 at offset 0x0C, and a new request in the same cycle wins over that clear.
- R9: The four command outputs and the two interrupt outputs follow their register bits, and each change shows at the outputs one clock after the edge that causes it.
- R10: Writes to any other address change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Byte address of the access |
| regWe | input | 1 | Write enable |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| evOverrun | input | 1 | Periodic schedule missed end of frame |
| evHandoffDone | input | 1 | Ownership handoff completed |
| evResetDone | input | 1 | Core reset finished |
| evCtrlEmpty | input | 1 | Control list found empty |
| evBulkEmpty | input | 1 | Bulk list found empty |
| cmdReset | output | 1 | Core reset request |
| cmdCtrlFilled | output | 1 | Control list has work |
| cmdBulkFilled | output | 1 | Bulk list has work |
| cmdHandoff | output | 1 | Ownership handoff request |
| irqOverrun | output | 1 | Overrun interrupt flag |
| irqHandoff | output | 1 | Handoff interrupt flag |

## Verification
Every write, event pulse and flag clear takes effect at the next rising edge. Its result is therefore due at the outputs and in the read data one clock after the edge on which the stimulus was sampled. Read data is combinational on the address, so it reflects the state as of that same edge. The bench drives each stimulus at a falling edge and steps its reference model by one edge. It compares every output at the following falling edge, exactly one register stage later. Same-cycle collisions are driven in one cycle, so the priority rules are checked on the very edge where they apply.

// File: rtl/usbh_cs_pkg.sv
package usbh_cs_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CMD   = 2'd1,
    SEL_ISTAT = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic   cmdWr;
    logic   istatWr;
    rdSel_e rdSel;
  } regStrobe_t;

  localparam int NUM_CMD     = 4;
  localparam int BIT_RESET   = 0;
  localparam int BIT_CTRL    = 1;
  localparam int BIT_BULK    = 2;
  localparam int BIT_HANDOFF = 3;
  localparam int CNT_LSB     = 16;
  localparam int IST_OVR     = 0;
  localparam int IST_HO      = 1;

endpackage

// File: rtl/usbh_cs_ctrl.sv
module usbh_cs_ctrl
  import usbh_cs_pkg::*;
#(
  parameter int              ADDR_W       = 8,
  parameter logic [ADDR_W-1:0] CMD_OFFSET   = 8'h08,
  parameter logic [ADDR_W-1:0] ISTAT_OFFSET = 8'h0C
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobe_t        strobe
);

  logic hitCmd;
  logic hitIstat;

  always_comb begin
    hitCmd   = (regAddr == CMD_OFFSET);
    hitIstat = (regAddr == ISTAT_OFFSET);
    strobe.cmdWr   = regWe & hitCmd;
    strobe.istatWr = regWe & hitIstat;
    if (hitCmd)        strobe.rdSel = SEL_CMD;
    else if (hitIstat) strobe.rdSel = SEL_ISTAT;
    else               strobe.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/usbh_cs_datapath.sv
module usbh_cs_datapath
  import usbh_cs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evOverrun,
  input  logic              evHandoffDone,
  input  logic              evResetDone,
  input  logic              evCtrlEmpty,
  input  logic              evBulkEmpty,
  output logic [NUM_CMD-1:0] cmdBits,
  output logic              irqOverrun,
  output logic              irqHandoff
);

  localparam int CNT_MSB = CNT_LSB + CNT_W - 1;
  localparam logic [DATA_W-1:0] CMD_MASK =
    (DATA_W'((1 << NUM_CMD) - 1)) | (DATA_W'((1 << CNT_W) - 1) << CNT_LSB);

  logic [NUM_CMD-1:0] clrEvt;
  logic [NUM_CMD-1:0] setReq;
  logic [CNT_W-1:0]   overrunCnt;
  logic               ovFlag;
  logic               hoFlag;

  always_comb begin
    clrEvt = '0;
    clrEvt[BIT_RESET]   = evResetDone;
    clrEvt[BIT_CTRL]    = evCtrlEmpty;
    clrEvt[BIT_BULK]    = evBulkEmpty;
    clrEvt[BIT_HANDOFF] = evHandoffDone;
    setReq = regWdata[NUM_CMD-1:0] & {NUM_CMD{strobe.cmdWr}};
  end

  // Command bits: a software set outranks the hardware clear
  for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (!rstN)          cmdBits[i] <= 1'b0;
      else if (setReq[i]) cmdBits[i] <= 1'b1;
      else if (clrEvt[i]) cmdBits[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          overrunCnt <= '0;
    else if (evOverrun) overrunCnt <= overrunCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                     ovFlag <= 1'b0;
    else if (evOverrun)                            ovFlag <= 1'b1;
    else if (strobe.istatWr && regWdata[IST_OVR]) ovFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                    hoFlag <= 1'b0;
    else if (setReq[BIT_HANDOFF])                hoFlag <= 1'b1;
    else if (strobe.istatWr && regWdata[IST_HO]) hoFlag <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    unique case (strobe.rdSel)
      SEL_CMD: begin
        regRdata[NUM_CMD-1:0]      = cmdBits;
        regRdata[CNT_MSB:CNT_LSB]  = overrunCnt;
      end
      SEL_ISTAT: begin
        regRdata[IST_OVR] = ovFlag;
        regRdata[IST_HO]  = hoFlag;
      end
      default: regRdata = '0;
    endcase
  end

  assign irqOverrun = ovFlag;
  assign irqHandoff = hoFlag;

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    evOverrun |=> overrunCnt == CNT_W'($past(overrunCnt) + 1'b1));

  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !evOverrun |=> $stable(overrunCnt));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    evOverrun |=> ovFlag);

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmdWr && regWdata[BIT_RESET]) |=> cmdBits[BIT_RESET]);

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits[BIT_HANDOFF] && !evHandoffDone) |=> cmdBits[BIT_HANDOFF]);

  a_r8_flag_on_request: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmdWr && regWdata[BIT_HANDOFF]) |=> hoFlag);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == SEL_CMD) |-> ((regRdata & ~CMD_MASK) == '0));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == SEL_NONE) |-> (regRdata == '0));

endmodule

// File: rtl/usbh_cmd_stat_reg.sv
module usbh_cmd_stat_reg
  import usbh_cs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              evOverrun,
  input  logic              evHandoffDone,
  input  logic              evResetDone,
  input  logic              evCtrlEmpty,
  input  logic              evBulkEmpty,
  output logic              cmdReset,
  output logic              cmdCtrlFilled,
  output logic              cmdBulkFilled,
  output logic              cmdHandoff,
  output logic              irqOverrun,
  output logic              irqHandoff
);

  regStrobe_t         strobe;
  logic [NUM_CMD-1:0] cmdBits;

  usbh_cs_ctrl #(
    .ADDR_W       (ADDR_W),
    .CMD_OFFSET   (ADDR_W'(8'h08)),
    .ISTAT_OFFSET (ADDR_W'(8'h0C))
  ) u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strobe  (strobe)
  );

  usbh_cs_datapath #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .regWdata      (regWdata),
    .regRdata      (regRdata),
    .evOverrun     (evOverrun),
    .evHandoffDone (evHandoffDone),
    .evResetDone   (evResetDone),
    .evCtrlEmpty   (evCtrlEmpty),
    .evBulkEmpty   (evBulkEmpty),
    .cmdBits       (cmdBits),
    .irqOverrun    (irqOverrun),
    .irqHandoff    (irqHandoff)
  );

  assign cmdReset      = cmdBits[BIT_RESET];
  assign cmdCtrlFilled = cmdBits[BIT_CTRL];
  assign cmdBulkFilled = cmdBits[BIT_BULK];
  assign cmdHandoff    = cmdBits[BIT_HANDOFF];

endmodule

// File: tb/usbh_cmd_stat_reg_bench.sv
module usbh_cmd_stat_reg_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = 32'h0;
  logic [31:0] regRdata;
  logic evOverrun = 1'b0, evHandoffDone = 1'b0, evResetDone = 1'b0;
  logic evCtrlEmpty = 1'b0, evBulkEmpty = 1'b0;
  logic cmdReset, cmdCtrlFilled, cmdBulkFilled, cmdHandoff, irqOverrun, irqHandoff;

  always #4 clk = ~clk;

  usbh_cmd_stat_reg u_usbh_cmd_stat_reg (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata),
    .evOverrun(evOverrun), .evHandoffDone(evHandoffDone),
    .evResetDone(evResetDone), .evCtrlEmpty(evCtrlEmpty),
    .evBulkEmpty(evBulkEmpty),
    .cmdReset(cmdReset), .cmdCtrlFilled(cmdCtrlFilled),
    .cmdBulkFilled(cmdBulkFilled), .cmdHandoff(cmdHandoff),
    .irqOverrun(irqOverrun), .irqHandoff(irqHandoff)
  );

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit finished = 0;

  // reference state
  int mReset = 0, mCtrl = 0, mBulk = 0, mHo = 0, mCnt = 0, mOvF = 0, mHoF = 0;

  function automatic int modelRead(int addr);
    if (addr == 8)  return (mCnt << 16) | (mHo << 3) | (mBulk << 2) | (mCtrl << 1) | mReset;
    if (addr == 12) return (mHoF << 1) | mOvF;
    return 0;
  endfunction

  task automatic check(string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, nm, act, exp);
    end
  endtask

  task automatic compareAll();
    check("cmdReset", int'(cmdReset), mReset);
    check("cmdCtrlFilled", int'(cmdCtrlFilled), mCtrl);
    check("cmdBulkFilled", int'(cmdBulkFilled), mBulk);
    check("cmdHandoff", int'(cmdHandoff), mHo);
    check("irqOverrun", int'(irqOverrun), mOvF);
    check("irqHandoff", int'(irqHandoff), mHoF);
    check("regRdata", int'(regRdata), modelRead(int'(regAddr)));
  endtask

  // one clock: drive at falling edge, model one edge, compare at next falling edge
  task automatic cyc(bit we, int addr, int wd, bit ov = 0, bit hd = 0,
                     bit rd = 0, bit ce = 0, bit be = 0);
    bit cw, iw;
    int nReset, nCtrl, nBulk, nHo, nCnt, nOvF, nHoF;
    regWe = we; regAddr = 8'(addr); regWdata = 32'(wd);
    evOverrun = ov; evHandoffDone = hd; evResetDone = rd;
    evCtrlEmpty = ce; evBulkEmpty = be;
    cw = we && addr == 8;
    iw = we && addr == 12;
    nReset = (cw && wd[0]) ? 1 : rd ? 0 : mReset;
    nCtrl  = (cw && wd[1]) ? 1 : ce ? 0 : mCtrl;
    nBulk  = (cw && wd[2]) ? 1 : be ? 0 : mBulk;
    nHo    = (cw && wd[3]) ? 1 : hd ? 0 : mHo;
    nCnt   = ov ? (mCnt + 1) % 4 : mCnt;
    nOvF   = ov ? 1 : (iw && wd[0]) ? 0 : mOvF;
    nHoF   = (cw && wd[3]) ? 1 : (iw && wd[1]) ? 0 : mHoF;
    @(posedge clk);
    @(negedge clk);
    mReset = nReset; mCtrl = nCtrl; mBulk = nBulk; mHo = nHo;
    mCnt = nCnt; mOvF = nOvF; mHoF = nHoF;
    compareAll();
    regWe = 0; evOverrun = 0; evHandoffDone = 0; evResetDone = 0;
    evCtrlEmpty = 0; evBulkEmpty = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at both addresses
    tag = "R1";
    regAddr = 8'h08; #1 compareAll();
    regAddr = 8'h0C; #1 compareAll();
    rstN = 1'b1;
    cyc(0, 8, 0);

    // R2: write-1-to-set, zeros leave bits alone; R9 output timing
    tag = "R2";
    cyc(1, 8, 32'h1);
    cyc(1, 8, 32'h2);
    cyc(1, 8, 32'h0);
    cyc(1, 8, 32'h4);
    tag = "R9";
    cyc(0, 8, 0);

    // R4: hardware clears
    tag = "R4";
    cyc(0, 8, 0, 0, 0, 1);
    cyc(0, 8, 0, 0, 0, 0, 1);
    cyc(0, 8, 0, 0, 0, 0, 0, 1);

    // R5: set and clear in the same cycle
    tag = "R5";
    cyc(1, 8, 32'h7, 0, 0, 1, 1, 1);
    cyc(1, 8, 32'h7, 0, 0, 1, 1, 1);
    cyc(0, 8, 0, 0, 0, 1, 1, 1);

    // R3: reserved and counter bits ignore writes
    tag = "R3";
    cyc(1, 8, 32'hFFFF_FFF0);
    cyc(0, 8, 0);

    // R6: counter steps and wraps, flag already pending
    tag = "R6";
    cyc(0, 8, 0, 1);
    cyc(0, 8, 0, 1);
    cyc(0, 8, 0);
    cyc(0, 8, 0, 1);
    cyc(0, 8, 0, 1);
    cyc(0, 8, 0, 1);
    cyc(0, 12, 0);

    // R7: overrun flag clear and set-beats-clear
    tag = "R7";
    cyc(1, 12, 32'h2);
    cyc(1, 12, 32'h1);
    cyc(0, 8, 0, 1);
    cyc(1, 12, 32'h1, 1);
    cyc(1, 12, 32'h1);
    cyc(0, 8, 0);

    // R8: handoff request and flag
    tag = "R8";
    cyc(1, 8, 32'h8);
    cyc(0, 12, 0);
    cyc(1, 12, 32'h1);
    cyc(1, 12, 32'h2);
    cyc(0, 8, 0);
    cyc(0, 8, 0, 0, 1);
    cyc(1, 8, 32'h8, 0, 1);
    cyc(0, 8, 0, 0, 1);
    cyc(1, 8, 32'h8);
    cyc(1, 12, 32'h2);
    cyc(0, 12, 0);

    // R10: other addresses
    tag = "R10";
    cyc(1, 8'h10, 32'hFFFF_FFFF);
    cyc(1, 8'h04, 32'hFFFF_FFFF);
    cyc(0, 8'h00, 0);
    cyc(0, 8, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule